// File: doc/BRIEF.md
# Timer interrupt flag register

This block keeps the interrupt status of a 16-bit timer/counter that has two output-compare channels and one input-capture channel. The timer core hands it one-cycle event strobes and the current 4-bit waveform mode. From these the block keeps four sticky flags: capture, compare A, compare B and overflow. Software reads the flags as one 8-bit status word. Software clears a flag by writing a one to its bit. The interrupt controller clears a flag when it signals that the vector for that flag is running. Each flag also drives an interrupt request, which is qualified by an enable mask.

The block sits between the timer core and the interrupt controller. Each flag is a small two-state machine. `FLG_IDLE` means no event is pending and `FLG_PEND` means an event is pending. There are three transitions. *set* moves a flag to `FLG_PEND`. *clear* moves it to `FLG_IDLE` and fires only when no set arrives in the same cycle. *hold* keeps the state. A routing stage picks the set source for each flag. It uses the waveform mode, delays compare matches by one cycle, and drops matches that come with a forced-compare strobe.

Top module: `timer_irq_flags`

## Requirements
- R1: After reset, all of `rd_data` and all of `irq` read zero.
- R2: Bits 7, 6, 4 and 3 of `rd_data` always read zero. A write to those bit positions changes no flag.
- R3: The capture flag is bit 5 of `rd_data`. In waveform modes 8, 10, 12 and 14 (capture register is TOP) it sets on the edge that samples `cnt_at_top`, and `cap_pin_evt` is ignored. In every other mode it sets on the edge that samples `cap_pin_evt`, and `cnt_at_top` is ignored.
- R4: Compare A is bit 1 and compare B is bit 2 of `rd_data`. `cmp_match[0]` is channel A and `cmp_match[1]` is channel B. A match sampled on edge k makes the flag read one after edge k+1, and it still reads zero after edge k.
- R5: If `cmp_force[n]` is high in the same cycle as `cmp_match[n]`, that match does not set the compare flag of channel n.
- R6: The overflow flag is bit 0 of `rd_data`. In modes 0, 4 and 12 it sets from `ovf_plain_stb`, and `ovf_alt_stb` is ignored. In all other modes it sets from `ovf_alt_stb`, and `ovf_plain_stb` is ignored.
- R7: A write (`wr_en` high) clears every flag whose bit in `wr_data` is one. Flags whose bit is zero keep their value.
- R8: A high `vec_ack[i]` clears flag i on that edge. The index order is 0 overflow, 1 compare A, 2 compare B, 3 capture.
- R9: When a set event and a clear (by write or by acknowledge) reach the same flag on the same edge, the flag ends up set.
- R10: `irq[i]` is high exactly when flag i is set and `irq_en[i]` is high. It uses the same index order as `vec_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wave_mode | input | 4 | Current waveform mode code |
| cap_pin_evt | input | 1 | Capture-pin event strobe |
| cnt_at_top | input | 1 | Counter reached TOP strobe |
| cmp_match | input | 2 | Counter equals compare register, [0]=A, [1]=B |
| cmp_force | input | 2 | Forced-compare strobe, [0]=A, [1]=B |
| ovf_plain_stb | input | 1 | Overflow strobe for the plain-count and clear-on-match modes |
| ovf_alt_stb | input | 1 | Mode-dependent overflow strobe for all other modes |
| wr_en | input | 1 | Status-register write strobe |
| wr_data | input | 8 | Write data; a one clears the flag at that bit |
| vec_ack | input | 4 | Vector acknowledge per flag |
| irq_en | input | 4 | Interrupt enable mask per flag |
| rd_data | output | 8 | Status register read value |
| irq | output | 4 | Interrupt request per flag |

## Verification
The bench targets the one-cycle compare delay. A design that set the flag on the match cycle would show the bit one cycle early. It also targets a forced strobe that arrives together with a match: a design that forgot the mask would raise the flag. The mode boundaries are tested with both capture sources and both overflow strobes active in every mode. A wrong mode decode would then set flags from the ignored source. A set colliding with a write-one or an acknowledge catches a design that gives clear priority and loses the event.

// File: rtl/tifr_pkg.sv
package tifr_pkg;
    localparam int NFLAGS = 4;
    localparam int REG_W  = 8;
    localparam int MODE_W = 4;
    localparam int NCMP   = 2;

    localparam int FI_OVF  = 0;
    localparam int FI_CMPA = 1;
    localparam int FI_CMPB = 2;
    localparam int FI_CAP  = 3;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

    function automatic int flag_bit(input int idx);
        case (idx)
            FI_OVF:  return 0;
            FI_CMPA: return 1;
            FI_CMPB: return 2;
            default: return 5;
        endcase
    endfunction

    function automatic logic mode_top_is_capture(input logic [MODE_W-1:0] m);
        return (m == 4'd8) || (m == 4'd10) || (m == 4'd12) || (m == 4'd14);
    endfunction

    function automatic logic mode_plain_overflow(input logic [MODE_W-1:0] m);
        return (m == 4'd0) || (m == 4'd4) || (m == 4'd12);
    endfunction
endpackage

// File: rtl/tifr_flag_cell.sv
module tifr_flag_cell
    import tifr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_i) state_d = FLG_PEND;
            FLG_PEND: if (clr_i && !set_i) state_d = FLG_IDLE;
            default:  state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLG_PEND);
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/tifr_event_route.sv
module tifr_event_route
    import tifr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cap_pin_i,
    input  logic              at_top_i,
    input  logic [NCMP-1:0]   match_i,
    input  logic [NCMP-1:0]   force_i,
    input  logic              ovf_plain_i,
    input  logic              ovf_alt_i,
    output logic [NFLAGS-1:0] set_o
);
    logic [NCMP-1:0] cmp_dly_q;

    generate
        for (genvar c = 0; c < NCMP; c++) begin : g_cmp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cmp_dly_q[c] <= 1'b0;
                else        cmp_dly_q[c] <= match_i[c] && !force_i[c];
            end
        end
    endgenerate

    always_comb begin
        set_o          = '0;
        set_o[FI_CMPA] = cmp_dly_q[0];
        set_o[FI_CMPB] = cmp_dly_q[1];
        set_o[FI_CAP]  = mode_top_is_capture(mode_i) ? at_top_i : cap_pin_i;
        set_o[FI_OVF]  = mode_plain_overflow(mode_i) ? ovf_plain_i : ovf_alt_i;
    end

    p_force_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i[0] && force_i[0]) |=> !set_o[FI_CMPA]);
endmodule

// File: rtl/tifr_reg_map.sv
module tifr_reg_map
    import tifr_pkg::*;
(
    input  logic [NFLAGS-1:0] flags_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_o,
    output logic [NFLAGS-1:0] wr_clr_o
);
    generate
        for (genvar i = 0; i < NFLAGS; i++) begin : g_map
            localparam int BP = flag_bit(i);
            assign wr_clr_o[i] = wr_en_i && wr_data_i[BP];
        end
    endgenerate

    always_comb begin
        rd_o = '0;
        for (int i = 0; i < NFLAGS; i++) rd_o[flag_bit(i)] = flags_i[i];
    end
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags
    import tifr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] wave_mode,
    input  logic              cap_pin_evt,
    input  logic              cnt_at_top,
    input  logic [NCMP-1:0]   cmp_match,
    input  logic [NCMP-1:0]   cmp_force,
    input  logic              ovf_plain_stb,
    input  logic              ovf_alt_stb,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [NFLAGS-1:0] vec_ack,
    input  logic [NFLAGS-1:0] irq_en,
    output logic [REG_W-1:0]  rd_data,
    output logic [NFLAGS-1:0] irq
);
    logic [NFLAGS-1:0] set_evt;
    logic [NFLAGS-1:0] wr_clr;
    logic [NFLAGS-1:0] flags;

    tifr_event_route u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (wave_mode),
        .cap_pin_i   (cap_pin_evt),
        .at_top_i    (cnt_at_top),
        .match_i     (cmp_match),
        .force_i     (cmp_force),
        .ovf_plain_i (ovf_plain_stb),
        .ovf_alt_i   (ovf_alt_stb),
        .set_o       (set_evt)
    );

    generate
        for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
            tifr_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_evt[i]),
                .clr_i  (wr_clr[i] || vec_ack[i]),
                .flag_o (flags[i])
            );
        end
    endgenerate

    tifr_reg_map u_map (
        .flags_i   (flags),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_o      (rd_data),
        .wr_clr_o  (wr_clr)
    );

    assign irq = flags & irq_en;

    p_cmp_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_match[0] && !cmp_force[0]) |=> ##1 rd_data[1]);
    p_cap_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_top_is_capture(wave_mode) && cnt_at_top) |=> rd_data[5]);
    p_ovf_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_plain_overflow(wave_mode) && ovf_plain_stb) |=> rd_data[0]);
    p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack[FI_OVF] && !set_evt[FI_OVF]) |=> !rd_data[0]);
endmodule

// File: tb/timer_irq_flags_tb.sv
`timescale 1ns/1ps
module timer_irq_flags_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] wave_mode = '0;
    logic       cap_pin_evt = 1'b0, cnt_at_top = 1'b0;
    logic [1:0] cmp_match = '0, cmp_force = '0;
    logic       ovf_plain_stb = 1'b0, ovf_alt_stb = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [3:0] vec_ack = '0, irq_en = '0;
    logic [7:0] rd_data;
    logic [3:0] irq;

    int tests = 0, fails = 0;
    bit done = 0;

    // reference state: index 0 ovf, 1 cmpA, 2 cmpB, 3 capture
    bit m_flag [4];
    bit m_pend [2];

    always #2.5 clk = ~clk;

    timer_irq_flags u_dut (
        .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .cap_pin_evt(cap_pin_evt),
        .cnt_at_top(cnt_at_top), .cmp_match(cmp_match), .cmp_force(cmp_force),
        .ovf_plain_stb(ovf_plain_stb), .ovf_alt_stb(ovf_alt_stb), .wr_en(wr_en),
        .wr_data(wr_data), .vec_ack(vec_ack), .irq_en(irq_en),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic bit capture_top(input int m);
        return m inside {8, 10, 12, 14};
    endfunction
    function automatic bit plain_ovf(input int m);
        return m inside {0, 4, 12};
    endfunction
    function automatic int pos_of(input int i);
        int p [4] = '{0, 1, 2, 5};
        return p[i];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_flag[i]) m_flag[i] = 0;
            foreach (m_pend[i]) m_pend[i] = 0;
        end else begin
            bit s [4];
            bit c;
            s[0] = plain_ovf(wave_mode) ? ovf_plain_stb : ovf_alt_stb;
            s[1] = m_pend[0];
            s[2] = m_pend[1];
            s[3] = capture_top(wave_mode) ? cnt_at_top : cap_pin_evt;
            for (int i = 0; i < 4; i++) begin
                c = vec_ack[i] || (wr_en && wr_data[pos_of(i)]);
                if (s[i]) m_flag[i] = 1;
                else if (c) m_flag[i] = 0;
            end
            for (int n = 0; n < 2; n++) m_pend[n] = cmp_match[n] && !cmp_force[n];
        end
    end

    function automatic logic [7:0] model_rd();
        logic [7:0] r = '0;
        for (int i = 0; i < 4; i++) r[pos_of(i)] = m_flag[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison with the reference model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] e;
            logic [3:0] ei;
            e = model_rd();
            for (int i = 0; i < 4; i++) ei[i] = m_flag[i] && irq_en[i];
            check("R2 reserved", {rd_data[7:6], rd_data[4:3]}, 4'h0);
            check("R3 capture", rd_data[5], e[5]);
            check("R4 compare", rd_data[2:1], e[2:1]);
            check("R6 overflow", rd_data[0], e[0]);
            check("R10 irq", irq, ei);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        cap_pin_evt = 0; cnt_at_top = 0; cmp_match = 0; cmp_force = 0;
        ovf_plain_stb = 0; ovf_alt_stb = 0; wr_en = 0; wr_data = 0; vec_ack = 0;
    endtask

    task automatic wipe();
        idle(); wr_en = 1; wr_data = 8'hFF; step(); idle(); step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        irq_en = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset rd", rd_data, 8'h00);
        check("R1 reset irq", irq, 4'h0);
        rst_n = 1; step();

        // R2: reserved writes do nothing, flags stay zero
        wr_en = 1; wr_data = 8'hD8; step(); idle(); step();
        check("R2 reserved write", rd_data, 8'h00);

        // R4: delay of one extra cycle
        cmp_match = 2'b01; step(); idle();
        check("R4 not yet", rd_data[1], 1'b0);
        step();
        check("R4 compare A set", rd_data[1], 1'b1);
        cmp_match = 2'b10; step(); idle(); step();
        check("R4 compare B set", rd_data[2], 1'b1);
        wipe();

        // R5: forced strobe with a match
        cmp_match = 2'b11; cmp_force = 2'b11; step(); idle(); step(); step();
        check("R5 forced ignored", rd_data[2:1], 2'b00);

        // R6: overflow source by mode
        wave_mode = 4'd0; ovf_alt_stb = 1; step(); idle();
        check("R6 alt ignored in mode 0", rd_data[0], 1'b0);
        ovf_plain_stb = 1; step(); idle();
        check("R6 plain in mode 0", rd_data[0], 1'b1);
        wipe();
        wave_mode = 4'd5; ovf_plain_stb = 1; step(); idle();
        check("R6 plain ignored in mode 5", rd_data[0], 1'b0);
        ovf_alt_stb = 1; step(); idle();
        check("R6 alt in mode 5", rd_data[0], 1'b1);
        wipe();

        // R3: capture source by mode
        wave_mode = 4'd14; cap_pin_evt = 1; step(); idle();
        check("R3 pin ignored in TOP mode", rd_data[5], 1'b0);
        cnt_at_top = 1; step(); idle();
        check("R3 TOP sets", rd_data[5], 1'b1);
        wipe();
        wave_mode = 4'd2; cnt_at_top = 1; step(); idle();
        check("R3 TOP ignored in mode 2", rd_data[5], 1'b0);
        cap_pin_evt = 1; step(); idle();
        check("R3 pin sets", rd_data[5], 1'b1);

        // R7: write-one clears selected, zero keeps
        wave_mode = 4'd0; ovf_plain_stb = 1; step(); idle();
        wr_en = 1; wr_data = 8'h20; step(); idle();
        check("R7 write-one clear", rd_data, 8'h01);

        // R8: acknowledge clears
        vec_ack = 4'b0001; step(); idle();
        check("R8 ack clear", rd_data, 8'h00);

        // R9: set beats clear
        ovf_plain_stb = 1; step(); idle();
        ovf_plain_stb = 1; vec_ack = 4'b0001; step(); idle();
        check("R9 set wins ack", rd_data[0], 1'b1);
        cap_pin_evt = 1; wr_en = 1; wr_data = 8'h20; step(); idle();
        check("R9 set wins write", rd_data[5], 1'b1);

        // R10: mask
        irq_en = 4'b0001; step();
        check("R10 masked irq", irq, 4'b0001);
        irq_en = 4'hF;
        wipe();

        // random stretch compared cycle by cycle against the model
        for (int k = 0; k < 600; k++) begin
            wave_mode = 4'($urandom_range(0, 15));
            cap_pin_evt = ($urandom_range(0, 3) == 0);
            cnt_at_top = ($urandom_range(0, 3) == 0);
            cmp_match = 2'($urandom);
            cmp_force = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
            ovf_plain_stb = ($urandom_range(0, 3) == 0);
            ovf_alt_stb = ($urandom_range(0, 3) == 0);
            wr_en = ($urandom_range(0, 4) == 0);
            wr_data = 8'($urandom);
            vec_ack = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
            irq_en = 4'($urandom);
            step();
        end
        idle(); step();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule